// File: doc/BRIEF.md
# External Interrupt Source Combiner

This block turns eight asynchronous interrupt pins into eight sticky interrupt request flags for a downstream priority controller. Before edge detection, each input picks its trigger signal with a 2-bit selector. The trigger can be its own pin, an internal alternate signal, the OR of the two, or the AND of the two. Inputs 4 to 7 take their alternates from internal peripheral signals: two receive lines and two real-time-clock events. Inputs 0 to 3 have a constant-zero alternate.

The eight selectors live in one 16-bit register written with a single strobe. Per-input edge sensitivity comes from a static configuration vector. Pins pass through a two-flop synchronizer. Alternates are already synchronous, so they are used directly.

When the selected edge appears on the combined signal, a request flag is set. The flag stays set until its acknowledge bit is pulsed. A write to the selection register reloads the previous-sample state with the value the new selection produces, so reprogramming a source cannot fake an edge.

Top module: `ext_irq_combiner`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sel_value` reads 0 and `irq_req` reads 0.
- R2: A clock edge with `cfg_wr` high loads `cfg_wdata` into `sel_value`. With `cfg_wr` low, `sel_value` holds regardless of `cfg_wdata`.
- R3: Selector code 00 makes the input's pin alone the trigger signal.
- R4: Selector code 01 makes the alternate alone the trigger signal, and the pin is then ignored. For inputs 0 to 3 the alternate is constant zero, so `alt_in[3:0]` never sets a flag.
- R5: Selector code 10 makes the trigger the OR of pin and alternate. A pin rise while the alternate is already high is therefore not an edge.
- R6: Selector code 11 makes the trigger the AND of pin and alternate.
- R7: Edge code 00 never sets the flag, 01 sets it on a rising edge, 10 on a falling edge, and 11 on either edge.
- R8: A set flag stays set until a cycle with its `ack` bit high clears it. A new edge in the same cycle as the acknowledge leaves the flag set.
- R9: A write to the selection register never itself causes a flag to set, even when the new selection changes the trigger level.
- R10: Input i uses bits [2i+1:2i] of both `sel_value` and `edge_mode`.
- R11: A pin change shows on `irq_req` after the third rising clock edge. An alternate change shows after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous interrupt pins |
| alt_in | input | 8 | Synchronous alternate signals (bits 3:0 unused) |
| cfg_wr | input | 1 | Selection register write strobe |
| cfg_wdata | input | 16 | Selection register write data, 2 bits per input |
| edge_mode | input | 16 | Edge sensitivity, 2 bits per input |
| ack | input | 8 | Per-input request clear |
| sel_value | output | 16 | Current selection register |
| irq_req | output | 8 | Sticky interrupt request flags |

## Verification
The bench reprograms a selector while the pin sits high and the new trigger level jumps to one. A design that keeps a free-running previous sample would raise a false request there.

It raises a pin while the OR-selected alternate is already high. A combiner that detects edges on the pin itself would fire on that rise. The AND test holds the pin high with the alternate low; a wrong gate would fire early or never.

Other probes:
- An alternate on inputs 0 to 3 that is not wired to zero would produce a request.
- Acknowledging in the same cycle as a new edge would, in a design that lets clear win, lose an interrupt.
- The pin latency is checked at two and at three edges, which catches a missing or extra synchronizer stage.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    typedef enum logic [1:0] {
        SRC_PIN = 2'b00,
        SRC_ALT = 2'b01,
        SRC_OR  = 2'b10,
        SRC_AND = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } level_pair_t;

    function automatic logic combine_src(src_sel_e sel, logic pin, logic alt);
        logic r;
        case (sel)
            SRC_PIN: r = pin;
            SRC_ALT: r = alt;
            SRC_OR:  r = pin | alt;
            default: r = pin & alt;
        endcase
        return r;
    endfunction

    function automatic logic edge_hit(edge_mode_e mode, level_pair_t lv);
        logic rise;
        logic fall;
        rise = lv.cur & ~lv.prev;
        fall = ~lv.cur & lv.prev;
        case (mode)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_ANY:  return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_selreg.sv
module eirq_selreg #(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] sel_next
);
    always_ff @(posedge clk) begin
        if (rst)     sel_q <= '0;
        else if (wr) sel_q <= wdata;
    end

    assign sel_next = wr ? wdata : sel_q;
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
    import eirq_pkg::*;
#(
    parameter bit HAS_ALT = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_s,
    input  logic       alt,
    input  logic [1:0] sel_cur,
    input  logic [1:0] sel_next,
    input  logic       wr,
    input  logic [1:0] mode,
    input  logic       ack,
    output logic       req
);
    logic        alt_eff;
    logic        lvl_cur;
    logic        lvl_next;
    logic        prev_q;
    logic        hit;
    level_pair_t lv;

    if (HAS_ALT) begin : g_alt
        assign alt_eff = alt;
    end else begin : g_zero
        assign alt_eff = alt & 1'b0;
    end

    assign lvl_cur  = combine_src(src_sel_e'(sel_cur),  pin_s, alt_eff);
    assign lvl_next = combine_src(src_sel_e'(sel_next), pin_s, alt_eff);
    assign lv       = '{cur: lvl_cur, prev: prev_q};
    assign hit      = ~wr & edge_hit(edge_mode_e'(mode), lv);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            req    <= 1'b0;
        end else begin
            prev_q <= wr ? lvl_next : lvl_cur;
            if (hit)      req <= 1'b1;
            else if (ack) req <= 1'b0;
        end
    end
endmodule

// File: rtl/ext_irq_combiner.sv
module ext_irq_combiner #(
    parameter int           N_IN        = 8,
    parameter int           SYNC_STAGES = 2,
    parameter logic [N_IN-1:0] ALT_MASK = 8'hF0,
    localparam int          SEL_W       = 2 * N_IN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_IN-1:0]  alt_in,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_wdata,
    input  logic [SEL_W-1:0] edge_mode,
    input  logic [N_IN-1:0]  ack,
    output logic [SEL_W-1:0] sel_value,
    output logic [N_IN-1:0]  irq_req
);
    logic [N_IN-1:0]  pin_s;
    logic [SEL_W-1:0] sel_next;

    eirq_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(pin_s)
    );

    eirq_selreg #(.SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
        .sel_q(sel_value), .sel_next(sel_next)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_ch
        eirq_chan #(.HAS_ALT(ALT_MASK[i])) u_ch (
            .clk(clk), .rst(rst),
            .pin_s(pin_s[i]), .alt(alt_in[i]),
            .sel_cur(sel_value[2*i +: 2]), .sel_next(sel_next[2*i +: 2]),
            .wr(cfg_wr), .mode(edge_mode[2*i +: 2]), .ack(ack[i]),
            .req(irq_req[i])
        );
    end
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
    parameter int N_IN = 8,
    localparam int SEL_W = 2 * N_IN
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic [SEL_W-1:0] cfg_wdata,
    input logic [SEL_W-1:0] edge_mode,
    input logic [N_IN-1:0]  ack,
    input logic [SEL_W-1:0] sel_value,
    input logic [N_IN-1:0]  irq_req
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sel_value == '0 && irq_req == '0));

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> sel_value == $past(cfg_wdata));

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(sel_value));

    for (genvar i = 0; i < N_IN; i++) begin : g_chk
        assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (irq_req[i] && !ack[i]) |=> irq_req[i]);

        assert_no_set_on_write_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_req[i]) |-> $past(!cfg_wr));

        assert_mode_off_R7: assert property (@(posedge clk) disable iff (rst)
            (!irq_req[i] && edge_mode[2*i +: 2] == 2'b00) |=> !irq_req[i]);
    end
endmodule

bind ext_irq_combiner eirq_checker #(.N_IN(N_IN)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .edge_mode(edge_mode), .ack(ack), .sel_value(sel_value), .irq_req(irq_req)
);

// File: tb/sim_ext_irq_combiner.sv
module sim_ext_irq_combiner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = '0;
    logic [7:0]  alt_in = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] edge_mode = '0;
    logic [7:0]  ack = '0;
    logic [15:0] sel_value;
    logic [7:0]  irq_req;

    always #2 clk = ~clk;

    ext_irq_combiner u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .alt_in(alt_in),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .edge_mode(edge_mode),
        .ack(ack), .sel_value(sel_value), .irq_req(irq_req)
    );

    typedef struct {
        logic [7:0]  irq;
        logic [15:0] sel;
        string       req;
    } exp_t;

    exp_t        sb[$];
    exp_t        mon_e;
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] exp_sel = '0;
    bit          done = 0;

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_out(logic [7:0] irq, string req);
        exp_t e;
        e.irq = irq;
        e.sel = exp_sel;
        e.req = req;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            mon_e = sb.pop_front();
            n_cmp++;
            if (irq_req !== mon_e.irq || sel_value !== mon_e.sel) begin
                n_bad++;
                $display("FAIL %s: irq_req=%b sel=%h, expected irq_req=%b sel=%h",
                         mon_e.req, irq_req, sel_value, mon_e.irq, mon_e.sel);
            end
        end
    end

    task automatic set_sel(int idx, logic [1:0] code);
        exp_sel[2*idx +: 2] = code;
        cfg_wdata = exp_sel;
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
        expect_out(8'h00, "R2/R10 selector write");
    endtask

    task automatic do_ack(logic [7:0] v);
        ack = v;
        step();
        ack = '0;
        expect_out(8'h00, "R8 acknowledge clears");
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            report();
        end
    end

    initial begin
        step(3);
        expect_out(8'h00, "R1 during reset");
        rst = 1'b0;
        step();
        expect_out(8'h00, "R1 after reset");

        // R2: data without strobe is ignored
        cfg_wdata = 16'hFFFF;
        step(2);
        expect_out(8'h00, "R2 hold without write");

        // R3 / R11: pin only, rising, latency three edges
        edge_mode[1:0] = 2'b01;
        pin_in[0] = 1'b1;
        step(2);
        expect_out(8'h00, "R11 not yet after two edges");
        step();
        expect_out(8'h01, "R3 pin rise sets flag");
        step(5);
        expect_out(8'h01, "R8 flag sticky");
        do_ack(8'h01);
        pin_in[0] = 1'b0;
        step(4);
        expect_out(8'h00, "R7 rising mode ignores fall");

        // R7 falling on input 1
        edge_mode[3:2] = 2'b10;
        pin_in[1] = 1'b1;
        step(4);
        expect_out(8'h00, "R7 falling mode ignores rise");
        pin_in[1] = 1'b0;
        step(3);
        expect_out(8'h02, "R7 falling edge sets");
        do_ack(8'h02);

        // R7 both edges on input 2
        edge_mode[5:4] = 2'b11;
        pin_in[2] = 1'b1;
        step(3);
        expect_out(8'h04, "R7 both: rise");
        do_ack(8'h04);
        pin_in[2] = 1'b0;
        step(3);
        expect_out(8'h04, "R7 both: fall");
        do_ack(8'h04);

        // R4 alternate only on input 7
        set_sel(7, 2'b01);
        edge_mode[15:14] = 2'b01;
        alt_in[7] = 1'b1;
        step();
        expect_out(8'h80, "R4/R11 alternate sets after one edge");
        do_ack(8'h80);
        pin_in[7] = 1'b1;
        step(4);
        expect_out(8'h00, "R4 pin ignored when alternate selected");

        // R4 inputs 0..3 have zero alternate
        set_sel(0, 2'b01);
        edge_mode[1:0] = 2'b11;
        alt_in[0] = 1'b1;
        step(2);
        alt_in[0] = 1'b0;
        step(2);
        expect_out(8'h00, "R4 input 0 alternate is zero");
        set_sel(3, 2'b01);
        edge_mode[7:6] = 2'b11;
        alt_in[3] = 1'b1;
        step(3);
        expect_out(8'h00, "R4/R10 input 3 alternate is zero");

        // R5 OR on input 5
        set_sel(5, 2'b10);
        edge_mode[11:10] = 2'b01;
        alt_in[5] = 1'b1;
        step();
        expect_out(8'h20, "R5 OR via alternate");
        do_ack(8'h20);
        pin_in[5] = 1'b1;
        step(4);
        expect_out(8'h00, "R5 pin rise while OR already high");
        alt_in[5] = 1'b0;
        pin_in[5] = 1'b0;
        step(4);
        pin_in[5] = 1'b1;
        step(3);
        expect_out(8'h20, "R5 OR via pin");
        do_ack(8'h20);

        // R6 AND on input 4
        set_sel(4, 2'b11);
        edge_mode[9:8] = 2'b01;
        pin_in[4] = 1'b1;
        step(4);
        expect_out(8'h00, "R6 AND pin alone");
        alt_in[4] = 1'b1;
        step();
        expect_out(8'h10, "R6 AND both high");
        do_ack(8'h10);

        // R9 selector change with pin high
        set_sel(6, 2'b01);
        edge_mode[13:12] = 2'b01;
        pin_in[6] = 1'b1;
        step(4);
        expect_out(8'h00, "R9 setup");
        set_sel(6, 2'b00);
        step(3);
        expect_out(8'h00, "R9 no spurious edge on reselect");
        pin_in[6] = 1'b0;
        step(4);
        pin_in[6] = 1'b1;
        step(3);
        expect_out(8'h40, "R9 real edge after reselect");
        do_ack(8'h40);

        // R8 set wins over ack in the same cycle
        alt_in[7] = 1'b0;
        step();
        alt_in[7] = 1'b1;
        ack = 8'h80;
        step();
        ack = '0;
        expect_out(8'h80, "R8 new edge beats ack");
        do_ack(8'h80);

        step(2);
        done = 1;
        report();
    end
endmodule